// File: doc/BRIEF.md
# Phase-Coherent FSK Tone Synthesizer

This block turns a serial transmit bit into a binary frequency-shift-keyed tone using nothing but a single master clock. A programmable divider counts master clocks per sine segment. Its terminal count is picked by the data bit, and each time it wraps it steps a 16-position phase sequencer. The sequencer position is translated into an 8-bit weighted amplitude code, which feeds an external weighted summing network and smoothing filter. With a 3.1872 MHz master clock, a data bit of 1 yields about 1302 Hz and a data bit of 0 about 2097 Hz. Both frequencies scale linearly with the clock.

A tone change only swaps the divider's reload value. The phase sequencer is never cleared, so the waveform stays continuous across bit boundaries. An active-low enable parks the amplitude code at mid-scale, which stands for half the supply, without stopping the sequencer. A free-running 1200 Hz square wave is derived from the same clock by fixed division and serves as the bit-rate reference.

Top module: `fsk_tone_synth`

## Requirements
- R1: While the divider is reloaded with data bit 1, each sine segment lasts exactly 153 master clocks, so a full 16-segment period lasts 2448 clocks.
- R2: While the divider is reloaded with data bit 0, each sine segment lasts exactly 95 master clocks, so a full period lasts 1520 clocks.
- R3: The phase index advances by exactly one, modulo 16, on the clock that ends a segment, and holds at all other times. A change of the data bit never resets it.
- R4: The data bit is sampled only on the clock where a segment ends. A change in the middle of a segment does not alter that segment's length.
- R5: While tx_en_n is 1 the amplitude code is 128 (mid-scale), and the phase index keeps advancing as in R1 to R3.
- R6: ref_clk toggles every 1328 master clocks. The first rise comes 1328 clocks after reset is released.
- R7: While tx_en_n is 0 the amplitude code for phase p is 128 + round(127·sin(2πp/16)). Phases 0 and 8 give 128, and the codes for p and p+8 sum to 256.
- R8: A synchronous active-high reset sets the phase index to 0, the amplitude code to 128 and ref_clk to 0, clears both dividers, and starts the first segment with the data-1 length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 1 | Serial transmit bit (1 = low tone, 0 = high tone) |
| tx_en_n | input | 1 | Transmit enable, active low; 1 forces mid-scale |
| level | output | 8 | Weighted amplitude code for the external summing network |
| phase_idx | output | 4 | Current sine segment, 0 to 15 |
| ref_clk | output | 1 | 1200 Hz bit-rate reference square wave |

## Verification
The assertions check several properties on every cycle. The phase index steps by one exactly on a segment end and holds otherwise. Every segment length is one of the two legal counts. The reference toggles only on its divider wrap. The amplitude code is mid-scale in standby and at phases 0 and 8. Which of the two counts applies depends on when the data bit was sampled, and only the bench's scenarios can show that: mid-segment data flips, tone switches where the phase must carry on, standby stretches and a second reset, all followed by a cycle-accurate reference model.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  localparam int PH_W = 4;
  localparam int NSEG = 16;

  // Quarter-wave sine samples at k*22.5 degrees, scaled by 1024.
  function automatic int quarter_frac(input int k);
    case (k)
      0:       return 0;
      1:       return 392;
      2:       return 724;
      3:       return 946;
      default: return 1024;
    endcase
  endfunction

  // Amplitude code for a segment: mid-scale plus or minus a rounded sine.
  function automatic int sine_code(input int ph, input int lvl_w);
    int mid;
    int amp;
    int q;
    int k;
    int a;
    mid = 1 << (lvl_w - 1);
    amp = mid - 1;
    q   = ph % 8;
    k   = (q <= 4) ? q : 8 - q;
    a   = (quarter_frac(k) * amp + 512) / 1024;
    return (ph % NSEG < 8) ? mid + a : mid - a;
  endfunction

endpackage

// File: rtl/fsk_seg_div.sv
module fsk_seg_div #(
  parameter int MARK_TC  = 153,
  parameter int SPACE_TC = 95
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_data,
  output logic seg_tick
);
  localparam int MAX_TC = (MARK_TC > SPACE_TC) ? MARK_TC : SPACE_TC;
  localparam int CW     = $clog2(MAX_TC);
  localparam logic [CW-1:0] MARK_LAST  = CW'(MARK_TC - 1);
  localparam logic [CW-1:0] SPACE_LAST = CW'(SPACE_TC - 1);

  logic [CW-1:0] cnt;
  logic          sel_mark;
  logic [CW-1:0] last;

  assign last     = sel_mark ? MARK_LAST : SPACE_LAST;
  assign seg_tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sel_mark <= 1'b1;
    end else if (seg_tick) begin
      cnt      <= '0;
      sel_mark <= tx_data;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_phase_seq.sv
module fsk_phase_seq #(
  parameter int LVL_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     seg_tick,
  input  logic                     tx_en_n,
  output logic [fsk_pkg::PH_W-1:0] phase,
  output logic [LVL_W-1:0]         level
);
  localparam logic [LVL_W-1:0] MID = LVL_W'(1 << (LVL_W - 1));

  logic [LVL_W-1:0] sine_lvl;

  always_ff @(posedge clk) begin
    if (rst)           phase <= '0;
    else if (seg_tick) phase <= phase + 1'b1;
  end

  assign sine_lvl = LVL_W'(fsk_pkg::sine_code(int'(phase), LVL_W));
  assign level    = tx_en_n ? MID : sine_lvl;
endmodule

// File: rtl/fsk_ref_div.sv
module fsk_ref_div #(
  parameter int HALF = 1328
) (
  input  logic clk,
  input  logic rst,
  output logic ref_tick,
  output logic ref_clk
);
  localparam int RW = $clog2(HALF);
  localparam logic [RW-1:0] LAST = RW'(HALF - 1);

  logic [RW-1:0] cnt;

  assign ref_tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ref_clk <= 1'b0;
    end else if (ref_tick) begin
      cnt     <= '0;
      ref_clk <= ~ref_clk;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth #(
  parameter int MARK_TC  = 153,
  parameter int SPACE_TC = 95,
  parameter int REF_HALF = 1328,
  parameter int LVL_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_data,
  input  logic             tx_en_n,
  output logic [LVL_W-1:0] level,
  output logic [3:0]       phase_idx,
  output logic             ref_clk
);
  logic seg_tick;
  logic ref_tick;

  fsk_seg_div #(.MARK_TC(MARK_TC), .SPACE_TC(SPACE_TC)) u_div (
    .clk(clk), .rst(rst), .tx_data(tx_data), .seg_tick(seg_tick)
  );

  fsk_phase_seq #(.LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst(rst), .seg_tick(seg_tick), .tx_en_n(tx_en_n),
    .phase(phase_idx), .level(level)
  );

  fsk_ref_div #(.HALF(REF_HALF)) u_ref (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ref_clk(ref_clk)
  );
endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk #(
  parameter int MARK_TC  = 153,
  parameter int SPACE_TC = 95,
  parameter int LVL_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en_n,
  input logic [LVL_W-1:0] level,
  input logic [3:0]       phase_idx,
  input logic             ref_clk,
  input logic             seg_tick,
  input logic             ref_tick
);
  localparam logic [LVL_W-1:0] MID = LVL_W'(1 << (LVL_W - 1));

  int gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= 0;
    else if (seg_tick) gap <= 0;
    else gap <= gap + 1;
  end

  // R1 R2: segment lengths, measured with a counter
  always_ff @(posedge clk) begin
    if (!rst && seg_tick) begin
      p_seg_len_r1_r2: assert (gap + 1 == MARK_TC || gap + 1 == SPACE_TC)
        else $error("segment length %0d", gap + 1);
    end
  end

  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    seg_tick |=> phase_idx == $past(phase_idx) + 4'd1);

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !seg_tick |=> $stable(phase_idx));

  p_standby_mid_r5: assert property (@(posedge clk) disable iff (rst)
    tx_en_n |-> level == MID);

  p_ref_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> ref_clk != $past(ref_clk));

  p_ref_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(ref_clk));

  p_zero_cross_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_idx == 4'd0 || phase_idx == 4'd8) |-> level == MID);
endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
  .MARK_TC(MARK_TC), .SPACE_TC(SPACE_TC), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .tx_en_n(tx_en_n), .level(level),
  .phase_idx(phase_idx), .ref_clk(ref_clk),
  .seg_tick(seg_tick), .ref_tick(ref_tick)
);

// File: tb/fsk_tone_synth_test.sv
`timescale 1ns/1ps
module fsk_tone_synth_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_data = 1'b1;
  logic       tx_en_n = 1'b1;
  logic [7:0] level;
  logic [3:0] phase_idx;
  logic       ref_clk;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  int m_cnt, m_tc, m_ph, m_ncyc;
  // interval measurement
  int cyc = 0, last_chg = -1, exp_gap = 0;
  int prev_ph = 0;

  fsk_tone_synth uut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_en_n(tx_en_n),
    .level(level), .phase_idx(phase_idx), .ref_clk(ref_clk)
  );

  always #10 clk = ~clk;

  function automatic int sinref(input int p);
    real x;
    int  m;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * p / 16.0);
    m = $rtoi($floor(((x < 0.0) ? -x : x) + 0.5));
    return (x < 0.0) ? 128 - m : 128 + m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_cnt = 0; m_tc = 153; m_ph = 0; m_ncyc = 0;
      last_chg = -1;
    end else begin
      m_ncyc++;
      m_cnt++;
      if (m_cnt == m_tc) begin
        m_cnt = 0;
        m_ph  = (m_ph + 1) % 16;
        m_tc  = tx_data ? 153 : 95;   // R4: sampled at reload only
      end
    end
  endtask

  task automatic compare();
    int exp_lvl;
    exp_lvl = tx_en_n ? 128 : sinref(m_ph);
    chk(int'(phase_idx) == m_ph, "R3 R4 phase", int'(phase_idx), m_ph);
    chk(int'(level) == exp_lvl, tx_en_n ? "R5 level" : "R7 level", int'(level), exp_lvl);
    chk(int'(ref_clk) == (m_ncyc / 1328) % 2, "R6 ref", int'(ref_clk), (m_ncyc / 1328) % 2);
    if (!rst && int'(phase_idx) != prev_ph) begin
      if (last_chg >= 0 && exp_gap != 0)
        chk(cyc - last_chg == exp_gap, (exp_gap == 153) ? "R1 gap" : "R2 gap",
            cyc - last_chg, exp_gap);
      last_chg = cyc;
    end
    prev_ph = int'(phase_idx);
  endtask

  task automatic run(input int n, input bit d, input bit en_n);
    repeat (n) begin
      tx_data = d;
      tx_en_n = en_n;
      @(posedge clk);
      @(negedge clk);
      cyc++;
      model_step();
      compare();
    end
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    run(3, 1'b1, 1'b0);
    // R8: reset state
    chk(level == 8'd128, "R8 reset level", int'(level), 128);
    chk(phase_idx == 4'd0, "R8 reset phase", int'(phase_idx), 0);
    chk(ref_clk == 1'b0, "R8 reset ref", int'(ref_clk), 0);
    rst = 1'b0;
    // R1: low tone, full period plus margin; first segment uses data-1 length
    exp_gap = 153;
    run(153 * 18, 1'b1, 1'b0);
    // switch to data 0: phase continues (R3)
    exp_gap = 0;
    run(160, 1'b0, 1'b0);
    exp_gap = 95;
    // R2
    run(95 * 17, 1'b0, 1'b0);
    exp_gap = 0;
    // R4: flip data every 37 clocks, mid-segment
    for (int i = 0; i < 40; i++) run(37, i[0], 1'b0);
    // R5: standby, phase keeps moving
    run(1500, 1'b1, 1'b1);
    chk(level == 8'd128, "R5 standby level", int'(level), 128);
    // R7: mirror symmetry over one disabled-off sweep
    run(153 * 17, 1'b1, 1'b0);
    for (int p = 0; p < 8; p++)
      chk(sinref(p) + sinref(p + 8) == 256, "R7 mirror", sinref(p) + sinref(p + 8), 256);
    // R8: second reset mid-run
    rst = 1'b1;
    run(2, 1'b0, 1'b0);
    chk(phase_idx == 4'd0 && level == 8'd128 && ref_clk == 1'b0, "R8 rereset",
        int'(phase_idx), 0);
    rst = 1'b0;
    // R6: first rise at exactly 1328 clocks after release
    run(1327, 1'b0, 1'b0);
    chk(ref_clk == 1'b0, "R6 before edge", int'(ref_clk), 0);
    run(1, 1'b0, 1'b0);
    chk(ref_clk == 1'b1, "R6 first rise", int'(ref_clk), 1);
    run(1400, 1'b1, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule